// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block watches the charge-pump drive of a frequency synthesizer and keeps a lock flag. It runs on the crystal-rate clock. It measures every charge-pump pulse in whole crystal cycles. A pulse is the time during which either the up or the down output is active. Once a pulse outlasts the width threshold, the block drops the lock flag at once. It does not wait for the pulse to end or for the reference period to close.

A once-per-reference-period strobe marks the end of each comparison period. A period is clean when no pulse in it grew too wide. The flag is raised again only after an unbroken run of clean periods. Losing lock is therefore fast, while regaining it takes eight to nine reference periods, depending on where the loop settles within a period. A registered over-width indication is also available, for a status path or for debug.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is asserted and right after it is released, `lock_o` and `wide_o` are 0 and the clean-period run is empty.
- R2: The pulse signal is `cp_up OR cp_dn`, and a pulse's width is the number of consecutive clock cycles in which it is high. A pulse of 1 cycle is narrow. A pulse of 2 or more cycles (threshold `WIDE_LIMIT` = 1) is too wide.
- R3: When a pulse reaches its second active cycle, `lock_o` is 0 after the clock edge that ends that cycle, whatever the state of `ref_stb`.
- R4: `wide_o` is 1 in the cycle after each active cycle in which the pulse width already exceeded the threshold, and 0 otherwise.
- R5: A reference period ends at a cycle with `ref_stb` = 1. An over-width detection in that strobe cycle belongs to the period that is closing.
- R6: `lock_o` becomes 1 at the edge of the eighth consecutive strobe whose period was clean (`GOOD_RUN` = 8), and at no other time.
- R7: A period that held an over-width pulse empties the run, so eight further clean periods are needed before `lock_o` rises.
- R8: The run saturates at eight, so any number of extra clean periods keeps `lock_o` at 1.
- R9: An up pulse followed in the very next cycle by a down pulse forms a single pulse, and a 1+1 cycle sequence of this kind is too wide.
- R10: Narrow pulses, even on every other cycle, never clear `lock_o` and never break the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_stb | input | 1 | One-cycle strobe closing each reference period |
| cp_up | input | 1 | Charge-pump up pulse |
| cp_dn | input | 1 | Charge-pump down pulse |
| lock_o | output | 1 | Lock flag |
| wide_o | output | 1 | Registered over-width indication |

## Verification
The hardest situations to reach are those at period edges:
- an over-wide pulse whose second cycle falls on the strobe cycle;
- a clean run that is broken after some but not all of its eight periods;
- an up pulse that hands over directly to a down pulse.

The stimulus builds each period from a start cycle and an up and a down length, so these cases can be placed to the cycle. A scoreboard compares both outputs on every cycle against a model written from the requirements.

// File: rtl/pll_ld_pkg.sv
package pll_ld_pkg;
  // Width of a counter that must hold values 0..maxval.
  function automatic int unsigned cnt_w(input int unsigned maxval);
    int unsigned w;
    w = $clog2(maxval + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/pll_ld_rst_sync.sv
module pll_ld_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/pll_ld_width.sv
module pll_ld_width #(
  parameter int unsigned WIDE_LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic over_now
);
  import pll_ld_pkg::*;
  localparam int unsigned WW = cnt_w(WIDE_LIMIT);
  localparam logic [WW-1:0] LIM = WW'(WIDE_LIMIT);

  logic [WW-1:0] wcnt_q, wcnt_d;

  // Over-width as soon as the pulse is active beyond LIM cycles.
  assign over_now = pulse && (wcnt_q == LIM);

  always_comb begin
    if (!pulse)          wcnt_d = '0;
    else if (wcnt_q == LIM) wcnt_d = wcnt_q;
    else                 wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end
endmodule

// File: rtl/pll_ld_run.sv
module pll_ld_run #(
  parameter int unsigned GOOD_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic over_now,
  output logic set_req
);
  import pll_ld_pkg::*;
  localparam int unsigned RW = cnt_w(GOOD_RUN);
  localparam logic [RW-1:0] RUN_MAX = RW'(GOOD_RUN);
  localparam logic [RW-1:0] RUN_PRE = RW'(GOOD_RUN - 1);

  logic          dirty_q, dirty_d;
  logic [RW-1:0] run_q, run_d;
  logic          period_bad;

  assign period_bad = dirty_q || over_now;
  assign set_req    = stb && !period_bad && (run_q >= RUN_PRE);

  always_comb begin
    run_d   = run_q;
    dirty_d = dirty_q;
    if (stb) begin
      dirty_d = 1'b0;
      if (period_bad)          run_d = '0;
      else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
    end else if (over_now) begin
      dirty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dirty_q <= 1'b0;
      run_q   <= '0;
    end else begin
      dirty_q <= dirty_d;
      run_q   <= run_d;
    end
  end
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int unsigned WIDE_LIMIT = 1,
  parameter int unsigned GOOD_RUN   = 8
) (
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic ref_stb,
  input  logic cp_up,
  input  logic cp_dn,
  output logic lock_o,
  output logic wide_o
);
  logic rst_int_n;
  logic pulse;
  logic over_now;
  logic set_req;
  logic lock_q, lock_d;
  logic wide_q;

  assign pulse = cp_up | cp_dn;

  pll_ld_rst_sync u_rst (
    .clk        (clk_xtal),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  pll_ld_width #(.WIDE_LIMIT(WIDE_LIMIT)) u_width (
    .clk      (clk_xtal),
    .rst_n    (rst_int_n),
    .pulse    (pulse),
    .over_now (over_now)
  );

  pll_ld_run #(.GOOD_RUN(GOOD_RUN)) u_run (
    .clk      (clk_xtal),
    .rst_n    (rst_int_n),
    .stb      (ref_stb),
    .over_now (over_now),
    .set_req  (set_req)
  );

  // Clearing wins over setting.
  always_comb begin
    lock_d = lock_q;
    if (over_now)     lock_d = 1'b0;
    else if (set_req) lock_d = 1'b1;
  end

  always_ff @(posedge clk_xtal or negedge rst_int_n) begin
    if (!rst_int_n) begin
      lock_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      wide_q <= over_now;
    end
  end

  assign lock_o = lock_q;
  assign wide_o = wide_q;
endmodule

// File: rtl/pll_ld_chk.sv
module pll_ld_chk (
  input logic clk_xtal,
  input logic rst_n,
  input logic ref_stb,
  input logic cp_up,
  input logic cp_dn,
  input logic lock_o,
  input logic wide_o
);
  // R4 and R3: an over-width report coincides with a cleared flag.
  a_r3_wide_drops_lock: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    wide_o |-> !lock_o);

  // R6: the flag rises only on a strobe edge.
  a_r6_set_on_strobe: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $rose(lock_o) |-> $past(ref_stb));

  // R5: no rise right after an over-width cycle.
  a_r5_no_set_after_wide: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $rose(lock_o) |-> !$past(wide_o));

  // R10: the flag falls only while a pulse is active.
  a_r10_fall_needs_pulse: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    $fell(lock_o) |-> $past(cp_up | cp_dn));

  // R2: an over-width report needs a pulse in the previous cycle.
  a_r2_wide_needs_pulse: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    wide_o |-> $past(cp_up | cp_dn));

  // R1: outputs are low while reset is asserted.
  always @(negedge clk_xtal) begin
    if (!rst_n) begin
      a_r1_reset_low: assert (!lock_o && !wide_o);
    end
  end
endmodule

bind pll_lock_detect pll_ld_chk u_chk (
  .clk_xtal (clk_xtal),
  .rst_n    (rst_n),
  .ref_stb  (ref_stb),
  .cp_up    (cp_up),
  .cp_dn    (cp_dn),
  .lock_o   (lock_o),
  .wide_o   (wide_o)
);

// File: tb/pll_lock_detect_tb_top.sv
`timescale 1ns/1ps
module pll_lock_detect_tb_top;
  localparam int PER_LEN = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_stb, cp_up, cp_dn;
  logic lock_o, wide_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit    lock;
    bit    wide;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // Model state, written from the requirements.
  int  m_width;
  bit  m_dirty;
  int  m_run;
  bit  m_lock;

  always #4 clk = ~clk;

  pll_lock_detect dut_i (
    .clk_xtal (clk),
    .rst_n    (rst_n),
    .ref_stb  (ref_stb),
    .cp_up    (cp_up),
    .cp_dn    (cp_dn),
    .lock_o   (lock_o),
    .wide_o   (wide_o)
  );

  task automatic check(input string tag, input string what, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: pop and compare.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, "lock_o", lock_o, e.lock);
      check(e.tag, "wide_o", wide_o, e.wide);
    end
  end

  // Driver: one cycle of stimulus, expected outputs pushed after the edge.
  task automatic step(input bit up, input bit dn, input bit stb, input string tag);
    bit act, over;
    exp_t e;
    @(negedge clk);
    cp_up = up; cp_dn = dn; ref_stb = stb;
    act  = up | dn;
    over = act && (m_width >= 1);            // R2: second active cycle is too wide
    if (over)                                 m_lock = 1'b0;   // R3
    else if (stb && !m_dirty && m_run >= 7)   m_lock = 1'b1;   // R6
    if (stb) begin                                             // R5, R7, R8
      m_run   = (m_dirty || over) ? 0 : ((m_run < 8) ? m_run + 1 : 8);
      m_dirty = 1'b0;
    end else if (over) m_dirty = 1'b1;
    m_width = act ? m_width + 1 : 0;
    e.lock = m_lock; e.wide = over; e.tag = tag;                // R4
    @(posedge clk);
    #1 sb_q.push_back(e);
  endtask

  // One reference period: up for ulen cycles from cycle s, then dn for dlen.
  task automatic period(input int s, input int ulen, input int dlen, input bit alt, input string tag);
    for (int c = 0; c < PER_LEN; c++) begin
      bit u, d;
      u = (c >= s) && (c < s + ulen);
      d = (c >= s + ulen) && (c < s + ulen + dlen);
      if (alt) u = (c % 2 == 0);
      step(u, d, c == PER_LEN - 1, tag);
    end
  endtask

  initial begin
    rst_n = 1'b0; ref_stb = 1'b0; cp_up = 1'b0; cp_dn = 1'b0;
    m_width = 0; m_dirty = 1'b0; m_run = 0; m_lock = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "lock_o in reset", lock_o, 1'b0);
    check("R1", "wide_o in reset", wide_o, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "lock_o after release", lock_o, 1'b0);

    // R6 and R10: eight clean periods with narrow pulses lock the loop.
    for (int p = 0; p < 8; p++) period(3 + p, 1, 0, 1'b0, "R6");
    check("R6", "lock after 8 clean", lock_o, 1'b1);
    // R8: saturation keeps lock.
    for (int p = 0; p < 3; p++) period(5, 0, 1, 1'b0, "R8");
    check("R8", "lock kept", lock_o, 1'b1);
    // R3: two-cycle up pulse mid-period clears lock.
    period(6, 2, 0, 1'b0, "R3");
    check("R3", "lock cleared", lock_o, 1'b0);
    // R7: four clean periods, a three-cycle dn pulse, then eight more.
    for (int p = 0; p < 4; p++) period(2, 1, 0, 1'b0, "R7");
    period(4, 0, 3, 1'b0, "R7");
    for (int p = 0; p < 7; p++) period(2, 0, 1, 1'b0, "R7");
    check("R7", "no lock after 7", lock_o, 1'b0);
    period(2, 0, 1, 1'b0, "R7");
    check("R7", "lock after 8", lock_o, 1'b1);
    // R9: up then dn back to back is one wide pulse.
    period(8, 1, 1, 1'b0, "R9");
    check("R9", "lock cleared", lock_o, 1'b0);
    // R5: over-wide whose second cycle is the strobe cycle.
    for (int p = 0; p < 8; p++) period(1, 1, 0, 1'b0, "R5");
    period(PER_LEN - 2, 2, 0, 1'b0, "R5");
    for (int p = 0; p < 7; p++) period(0, 0, 0, 1'b0, "R5");
    check("R5", "strobe-cycle wide counted", lock_o, 1'b0);
    // R10: alternating narrow pulses relock and never clear.
    for (int p = 0; p < 10; p++) period(0, 0, 0, 1'b1, "R10");
    check("R10", "lock with alternating pulses", lock_o, 1'b1);
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule